// File: doc/BRIEF.md
# Key-Sequence Access Guard Register

This block is a write-only guard register on a simple memory-mapped write port. Software opens a protected information region by writing three fixed 32-bit key words to the guard address, one after another, in one exact order. The block follows the progress through that order. When the last key arrives, it raises a registered access-grant output. The protected memory and its own access checks sit outside this block and use that output.

While access is granted, any write to the guard address takes the grant away and puts the sequence back at its start, whatever the written value is. Reads of the guard address always return zero, so the lock state cannot be seen through the register. Writes and reads at any other address leave the block unchanged. The number of keys, their values, the address width and the guard address are parameters. The defaults give a three-key sequence at offset 0x40 of an 8-bit address space.

Top module: `seqkey_guard`

## Requirements
- R1: While `rst_n` is low, `grant` is 0, and reset throws away any partial progress. After reset, a single write of the last key alone does not grant access.
- R2: A write at the guard address (default 0x40) with data 0x3A7F5CA3, then one with 0xA1E34F20, then one with 0x9608B2C1, raises `grant` on the clock edge that takes the third write. `grant` stays 0 after the first and second writes.
- R3: A guard-address write whose data is not the next expected key (and is not the first key) puts the sequence back at its start. The full three-key order is then needed again before `grant` can rise.
- R4: A mismatching guard-address write whose data equals the first key (0x3A7F5CA3) counts as step one of a new attempt.
- R5: While `grant` is 1, any write to the guard address clears `grant` on that clock edge. That write is not counted as a key, so the next grant needs all three keys again.
- R6: Writes to any address other than the guard address change neither the sequence progress nor `grant`.
- R7: A read at the guard address raises `rd_valid` for one cycle, on the edge after the request. `rd_data` is always zero. Reads never change progress or `grant`.
- R8: Once raised, `grant` stays 1 for as long as no write reaches the guard address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W (8) | Write address |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (8) | Read address |
| rd_data | output | DATA_W (32) | Read data, always zero |
| rd_valid | output | 1 | Read response for the guard address, one cycle after `rd_en` |
| grant | output | 1 | Access grant for the protected region |

## Verification
The step counter is the only hidden state, and `grant` shows nothing of it until a third key write arrives. A wrong step therefore shows up only as a grant that is missing or that comes too early, at the end of a key series. That can be several writes after the fault. For this reason the bench sweeps every series of three and four words drawn from the three keys plus one non-key word, and checks `grant` after each write. A wrong relock or a disturbance from another address shows on `grant` at the very next edge.

// File: rtl/seqkey_pkg.sv
package seqkey_pkg;
   localparam int unsigned KEY_W     = 32;
   localparam int unsigned KEY_COUNT = 3;
   // key i sits at bits [i*KEY_W +: KEY_W]; index 0 is written first
   localparam logic [KEY_COUNT*KEY_W-1:0] DEFAULT_KEYS =
      {32'h9608_B2C1, 32'hA1E3_4F20, 32'h3A7F_5CA3};
   localparam logic [7:0] DEFAULT_GUARD_ADDR = 8'h40;
endpackage

// File: rtl/seqkey_decode.sv
module seqkey_decode #(
   parameter int unsigned       ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] GUARD_ADDR = '0
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              wr_hit,
   output logic              rd_hit
);
   assign wr_hit = wr_en && (wr_addr == GUARD_ADDR);
   assign rd_hit = rd_en && (rd_addr == GUARD_ADDR);
endmodule

// File: rtl/seqkey_match.sv
module seqkey_match #(
   parameter int unsigned                   DATA_W   = 32,
   parameter int unsigned                   NUM_KEYS = 3,
   parameter logic [NUM_KEYS*DATA_W-1:0]    KEYS     = '0
) (
   input  logic [DATA_W-1:0]   data,
   output logic [NUM_KEYS-1:0] match
);
   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      assign match[k] = (data == KEYS[k*DATA_W +: DATA_W]);
   end
endmodule

// File: rtl/seqkey_fsm.sv
module seqkey_fsm #(
   parameter int unsigned NUM_KEYS = 3,
   parameter int unsigned STEP_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_hit,
   input  logic [NUM_KEYS-1:0] match,
   output logic [STEP_W-1:0]   step,
   output logic                grant
);
   logic              exp_hit;
   logic              at_last;
   logic [STEP_W-1:0] step_n;
   logic              grant_n;

   always_comb begin
      exp_hit = 1'b0;
      for (int i = 0; i < NUM_KEYS; i++) begin
         if (step == STEP_W'(i)) exp_hit = match[i];
      end
   end

   assign at_last = (step == STEP_W'(NUM_KEYS - 1));

   always_comb begin
      step_n  = step;
      grant_n = grant;
      if (wr_hit) begin
         if (grant) begin
            grant_n = 1'b0;
            step_n  = '0;
         end else if (exp_hit) begin
            if (at_last) begin
               grant_n = 1'b1;
               step_n  = '0;
            end else begin
               step_n = step + STEP_W'(1);
            end
         end else if (match[0]) begin
            step_n = STEP_W'(1);
         end else begin
            step_n = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step  <= '0;
         grant <= 1'b0;
      end else begin
         step  <= step_n;
         grant <= grant_n;
      end
   end
endmodule

// File: rtl/seqkey_guard.sv
module seqkey_guard
   import seqkey_pkg::*;
#(
   parameter int unsigned                ADDR_W     = 8,
   parameter int unsigned                DATA_W     = KEY_W,
   parameter int unsigned                NUM_KEYS   = KEY_COUNT,
   parameter logic [ADDR_W-1:0]          GUARD_ADDR = DEFAULT_GUARD_ADDR,
   parameter logic [NUM_KEYS*DATA_W-1:0] KEYS       = DEFAULT_KEYS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              grant
);
   localparam int unsigned STEP_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;

   if (NUM_KEYS < 2) begin : g_bad_keys
      $error("seqkey_guard: NUM_KEYS must be at least 2");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("seqkey_guard: DATA_W must be at least 8");
   end

   logic                wr_hit;
   logic                rd_hit;
   logic [NUM_KEYS-1:0] match;
   logic [STEP_W-1:0]   step;

   seqkey_decode #(.ADDR_W(ADDR_W), .GUARD_ADDR(GUARD_ADDR)) u_decode (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .rd_en  (rd_en),
      .rd_addr(rd_addr),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit)
   );

   seqkey_match #(.DATA_W(DATA_W), .NUM_KEYS(NUM_KEYS), .KEYS(KEYS)) u_match (
      .data (wr_data),
      .match(match)
   );

   seqkey_fsm #(.NUM_KEYS(NUM_KEYS), .STEP_W(STEP_W)) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hit(wr_hit),
      .match (match),
      .step  (step),
      .grant (grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_hit;
   end

   assign rd_data = '0;
endmodule

// File: rtl/seqkey_guard_chk.sv
module seqkey_guard_chk #(
   parameter int unsigned                ADDR_W     = 8,
   parameter int unsigned                DATA_W     = 32,
   parameter int unsigned                NUM_KEYS   = 3,
   parameter int unsigned                STEP_W     = 2,
   parameter logic [ADDR_W-1:0]          GUARD_ADDR = '0,
   parameter logic [NUM_KEYS*DATA_W-1:0] KEYS       = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_valid,
   input logic              grant,
   input logic [STEP_W-1:0] step
);
   localparam logic [DATA_W-1:0] LAST_KEY = KEYS[(NUM_KEYS-1)*DATA_W +: DATA_W];

   logic at_guard_wr;
   assign at_guard_wr = wr_en && (wr_addr == GUARD_ADDR);

   a_r1_reset_locked: assert property (@(posedge clk) !rst_n |-> !grant);

   a_r2_rise_on_last_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> $past(at_guard_wr && wr_data == LAST_KEY));

   a_r3_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      step < STEP_W'(NUM_KEYS));

   a_r5_any_write_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      grant && at_guard_wr |=> !grant && step == '0);

   a_r6_other_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !at_guard_wr |=> $stable(step) && $stable(grant));

   a_r7_read_response: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_addr == GUARD_ADDR |=> rd_valid);

   a_r8_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
      grant && !at_guard_wr |=> grant);
endmodule

bind seqkey_guard seqkey_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_KEYS(NUM_KEYS), .STEP_W(STEP_W),
   .GUARD_ADDR(GUARD_ADDR), .KEYS(KEYS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .grant(grant), .step(step)
);

// File: tb/seqkey_guard_bench.sv
module seqkey_guard_bench;
   localparam logic [7:0]  GA   = 8'h40;
   localparam logic [31:0] K0   = 32'h3A7F_5CA3;
   localparam logic [31:0] K1   = 32'hA1E3_4F20;
   localparam logic [31:0] K2   = 32'h9608_B2C1;
   localparam logic [31:0] JUNK = 32'h1234_5678;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic        grant;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   seqkey_guard u_seqkey_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
      .grant(grant)
   );

   function automatic logic [31:0] word(int i);
      case (i)
         0: return K0;
         1: return K1;
         2: return K2;
         default: return JUNK;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge; on return the rising edge has taken the write
   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic unlock();
      wr(GA, K0); wr(GA, K1); wr(GA, K2);
   endtask

   initial begin
      #3_000_000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 grant in reset", {31'b0, grant}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 grant after reset", {31'b0, grant}, 32'd0);
      wr(GA, K2);
      check("R1 lone last key", {31'b0, grant}, 32'd0);

      // R2 basic unlock with per-step observation
      wr(GA, JUNK);
      wr(GA, K0); check("R2 after key0", {31'b0, grant}, 32'd0);
      wr(GA, K1); check("R2 after key1", {31'b0, grant}, 32'd0);
      wr(GA, K2); check("R2 after key2", {31'b0, grant}, 32'd1);

      // R8 hold with idle cycles and foreign writes
      repeat (5) @(negedge clk);
      wr(8'h41, JUNK);
      check("R8 grant holds", {31'b0, grant}, 32'd1);

      // R7 reads return zero and do not relock
      rd(GA);
      check("R7 rd_valid", {31'b0, rd_valid}, 32'd1);
      check("R7 rd_data zero while granted", rd_data, 32'd0);
      @(negedge clk);
      check("R7 rd_valid one cycle", {31'b0, rd_valid}, 32'd0);
      check("R7 read keeps grant", {31'b0, grant}, 32'd1);
      rd(8'h44);
      check("R7 no valid off-address", {31'b0, rd_valid}, 32'd0);

      // R5 relock by a key value; the relocking write is not step one
      wr(GA, K0);
      check("R5 relock", {31'b0, grant}, 32'd0);
      wr(GA, K1); wr(GA, K2);
      check("R5 relock write not counted", {31'b0, grant}, 32'd0);

      // R3 broken sequence
      wr(GA, JUNK);
      wr(GA, K0); wr(GA, K1); wr(GA, JUNK); wr(GA, K2);
      check("R3 broken sequence", {31'b0, grant}, 32'd0);
      wr(GA, K1); unlock();
      check("R3 restart after mismatch", {31'b0, grant}, 32'd1);
      wr(GA, JUNK);

      // R4 first key restarts as step one
      wr(GA, K0); wr(GA, K0); wr(GA, K1); wr(GA, K2);
      check("R4 repeated key0", {31'b0, grant}, 32'd1);
      wr(GA, JUNK);
      wr(GA, K0); wr(GA, K1); wr(GA, K0); wr(GA, K1); wr(GA, K2);
      check("R4 key0 after key1", {31'b0, grant}, 32'd1);
      wr(GA, JUNK);

      // R6 foreign writes between keys and keys to foreign addresses
      wr(GA, K0); wr(8'h00, JUNK); wr(GA, K1); wr(8'hC0, K0); wr(GA, K2);
      check("R6 interleaved foreign writes", {31'b0, grant}, 32'd1);
      wr(GA, JUNK);
      wr(8'h3F, K0); wr(8'h3F, K1); wr(8'h3F, K2);
      check("R6 keys at other address", {31'b0, grant}, 32'd0);

      // R7 read mid-sequence does not disturb progress
      wr(GA, K0); rd(GA); wr(GA, K1); rd(GA); wr(GA, K2);
      check("R7 reads mid-sequence", {31'b0, grant}, 32'd1);
      wr(GA, JUNK);

      // R1 reset mid-sequence
      wr(GA, K0); wr(GA, K1);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      wr(GA, K2);
      check("R1 reset drops progress", {31'b0, grant}, 32'd0);

      // R2 R3 sweep: all three-word series
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++) begin
               wr(GA, JUNK);
               wr(GA, word(a)); check("R3 sweep3 w0", {31'b0, grant}, 32'd0);
               wr(GA, word(b)); check("R3 sweep3 w1", {31'b0, grant}, 32'd0);
               wr(GA, word(c));
               check("R2 sweep3 w2", {31'b0, grant},
                     {31'b0, (a == 0 && b == 1 && c == 2)});
            end

      // R4 R5 sweep: all four-word series
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int d = 0; d < 4; d++) begin
                  bit g2;
                  bit g3;
                  g2 = (a == 0 && b == 1 && c == 2);
                  g3 = !g2 && (b == 0 && c == 1 && d == 2);
                  wr(GA, JUNK);
                  wr(GA, word(a)); wr(GA, word(b)); wr(GA, word(c));
                  check("R4 sweep4 w2", {31'b0, grant}, {31'b0, g2});
                  wr(GA, word(d));
                  check("R5 sweep4 w3", {31'b0, grant}, {31'b0, g3});
               end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule